// File: doc/BRIEF.md
# Shared-Adder Eight-Function ALU

This block is a purely combinational arithmetic-logic unit for two unsigned byte operands. A three-bit operation code, given on three separate select pins, picks one of eight functions: add, subtract, double, halve, and four bitwise logic functions. The result appears on an output byte in the same evaluation, with no clock, state or flags.

All eight functions leave the block through one shared ripple-carry adder. A front-end operand shaper is built from one bit slice repeated once per bit position. It forms the adder's two operands for the chosen function. A separate piece of logic forms the adder's carry-in. Subtraction is done as two's-complement addition. The shifts are done by routing neighbouring bits. The logic functions are computed in the slices and sent through the adder with a zero second operand and a zero carry-in, so the adder passes them through unchanged. The unit is meant to sit inside a datapath whose surrounding registers supply stable operands and capture the result.

Top module: `adder_alu`

## Requirements
- R1: The operation code is {op_hi, op_mid, op_lo}, with op_hi as its most significant bit. Codes 000 to 111 select, in order: subtract, add, double, halve, NAND, XOR, NOR, invert.
- R2: With code 001 the result equals (in_a + in_b) modulo 256.
- R3: With code 000 the result equals (in_a - in_b) modulo 256. It is formed as in_a plus the inverse of in_b, with a carry-in of 1.
- R4: With code 010 the result equals in_a shifted left one place. Bit 0 of the result is 0 and bit 7 of in_a is lost.
- R5: With code 011 the result equals in_a shifted right one place, logically. Bit 7 of the result is 0.
- R6: With codes 100, 101 and 110 the result is, bit by bit, NAND, XOR and NOR of in_a and in_b respectively.
- R7: With code 111 the result is the bitwise complement of in_a, and in_b has no effect.
- R8: The adder's carry-out is dropped, so sums and differences wrap: 0xFF + 0x01 gives 0x00 and 0x00 - 0x01 gives 0xFF.
- R9: The adder carry-in is 1 only for code 000. The second adder operand is zero for every code from 010 to 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_a | input | 8 | First operand |
| in_b | input | 8 | Second operand |
| op_hi | input | 1 | Operation code bit 2 (most significant) |
| op_mid | input | 1 | Operation code bit 1 |
| op_lo | input | 1 | Operation code bit 0 |
| result | output | 8 | Function result, modulo 256 |

## Verification
The checker's immediate assertions assume that every input carries a known 0 or 1. They also assume the result is read only after the ripple chain has settled for the present operands and code. The stimulus drives all five inputs together from one task and never uses X or Z. It waits a fixed settling interval before each comparison and places every comparison between clock edges. The sweep covers every operand pair under every code, so each carry pattern the shared adder can see is applied.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SUB  = 3'b000,
    OP_ADD  = 3'b001,
    OP_DBL  = 3'b010,
    OP_HALF = 3'b011,
    OP_NAND = 3'b100,
    OP_XOR  = 3'b101,
    OP_NOR  = 3'b110,
    OP_INV  = 3'b111
  } alu_op_e;

endpackage

// File: rtl/alu_ext_slice.sv
module alu_ext_slice
  import alu_pkg::*;
(
  input  alu_op_e op,
  input  logic    a_bit,
  input  logic    b_bit,
  input  logic    a_lower,   // bit below this one (for left shift)
  input  logic    a_upper,   // bit above this one (for right shift)
  output logic    opa_bit,
  output logic    opb_bit
);

  always_comb begin
    opa_bit = 1'b0;
    opb_bit = 1'b0;
    unique case (op)
      OP_SUB:  begin opa_bit = a_bit;            opb_bit = ~b_bit; end
      OP_ADD:  begin opa_bit = a_bit;            opb_bit = b_bit;  end
      OP_DBL:  opa_bit = a_lower;
      OP_HALF: opa_bit = a_upper;
      OP_NAND: opa_bit = ~(a_bit & b_bit);
      OP_XOR:  opa_bit = a_bit ^ b_bit;
      OP_NOR:  opa_bit = ~(a_bit | b_bit);
      OP_INV:  opa_bit = ~a_bit;
      default: begin opa_bit = 1'b0; opb_bit = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu_cin_gen.sv
module alu_cin_gen
  import alu_pkg::*;
(
  input  alu_op_e op,
  output logic    cin
);

  // Only subtraction needs the +1 that completes two's complement of B.
  always_comb begin
    cin = 1'b0;
    if (op == OP_SUB) cin = 1'b1;
  end

endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  output logic [W-1:0] sum
);

  logic [W-1:0] carry;

  assign carry[0] = cin;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic half;
      assign half   = opa[i] ^ opb[i];
      assign sum[i] = half ^ carry[i];
      if (i < W - 1) begin : g_carry
        assign carry[i+1] = (opa[i] & opb[i]) | (carry[i] & half);
      end
      // The carry out of the top bit is not formed: results wrap.
    end
  endgenerate

endmodule

// File: rtl/adder_alu.sv
module adder_alu
  import alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         op_hi,
  input  logic         op_mid,
  input  logic         op_lo,
  output logic [W-1:0] result
);

  alu_op_e      op;
  logic [W-1:0] shl_src;
  logic [W-1:0] shr_src;
  logic [W-1:0] ext_a;
  logic [W-1:0] ext_b;
  logic         ext_cin;

  assign op      = alu_op_e'({op_hi, op_mid, op_lo});
  assign shl_src = {in_a[W-2:0], 1'b0};
  assign shr_src = {1'b0, in_a[W-1:1]};

  generate
    for (genvar i = 0; i < W; i++) begin : g_slice
      alu_ext_slice u_slice (
        .op      (op),
        .a_bit   (in_a[i]),
        .b_bit   (in_b[i]),
        .a_lower (shl_src[i]),
        .a_upper (shr_src[i]),
        .opa_bit (ext_a[i]),
        .opb_bit (ext_b[i])
      );
    end
  endgenerate

  alu_cin_gen u_cin (
    .op  (op),
    .cin (ext_cin)
  );

  alu_ripple_add #(.W(W)) u_add (
    .opa (ext_a),
    .opb (ext_b),
    .cin (ext_cin),
    .sum (result)
  );

endmodule

// File: rtl/adder_alu_chk.sv
module adder_alu_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [2:0]   code,
  input logic [W-1:0] result,
  input logic [W-1:0] opb,
  input logic         cin
);

  logic [W-1:0] want_sum;
  logic [W-1:0] want_diff;

  always_comb begin
    want_sum  = in_a + in_b;
    want_diff = in_a - in_b;

    if (code == 3'b001)
      a_r2_add: assert (result == want_sum)
        else $error("a_r2_add: result %h", result);

    if (code == 3'b000)
      a_r3_sub: assert (result == want_diff)
        else $error("a_r3_sub: result %h", result);

    if (code == 3'b010)
      a_r4_shl_lsb: assert (result[0] == 1'b0 && result[W-1:1] == in_a[W-2:0])
        else $error("a_r4_shl_lsb: result %h", result);

    if (code == 3'b011)
      a_r5_shr_msb: assert (result[W-1] == 1'b0 && result[W-2:0] == in_a[W-1:1])
        else $error("a_r5_shr_msb: result %h", result);

    if (code == 3'b101)
      a_r6_xor: assert ((result ^ in_b) == in_a)
        else $error("a_r6_xor: result %h", result);

    if (code == 3'b111)
      a_r7_inv: assert ((result & in_a) == '0 && (result | in_a) == '1)
        else $error("a_r7_inv: result %h", result);

    a_r9_cin: assert (cin == (code == 3'b000))
      else $error("a_r9_cin: cin %b code %b", cin, code);

    if (code[2] | code[1])
      a_r9_opb_zero: assert (opb == '0)
        else $error("a_r9_opb_zero: opb %h", opb);
  end

endmodule

bind adder_alu adder_alu_chk #(.W(W)) u_chk (
  .in_a   (in_a),
  .in_b   (in_b),
  .code   ({op_hi, op_mid, op_lo}),
  .result (result),
  .opb    (ext_b),
  .cin    (ext_cin)
);

// File: tb/sim_adder_alu.sv
`timescale 1ns/1ps
module sim_adder_alu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       op_hi = 1'b0, op_mid = 1'b0, op_lo = 1'b0;
  logic [7:0] result;

  int  n_chk  = 0;
  int  n_fail = 0;
  int  cycles = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  adder_alu u0 (
    .in_a   (in_a),
    .in_b   (in_b),
    .op_hi  (op_hi),
    .op_mid (op_mid),
    .op_lo  (op_lo),
    .result (result)
  );

  function automatic string tag_of(input int code);
    case (code)
      0: return "R3";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      7: return "R7";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [7:0] model(input int code, input int a, input int b);
    int r;
    case (code)
      0: r = (a - b + 256) % 256;
      1: r = (a + b) % 256;
      2: r = (a * 2) % 256;
      3: r = a / 2;
      4: r = 255 - (a & b);
      5: r = a ^ b;
      6: r = 255 - (a | b);
      default: r = 255 - a;
    endcase
    return r[7:0];
  endfunction

  task automatic apply(input int code, input int a, input int b, input string tag);
    logic [7:0] exp;
    {op_hi, op_mid, op_lo} = code[2:0];
    in_a = a[7:0];
    in_b = b[7:0];
    #0.125;
    exp = model(code, a, b);
    n_chk++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s code=%0d a=%h b=%h actual=%h expected=%h",
               tag, code, a[7:0], b[7:0], result, exp);
    end
    #0.125;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    #0.05;
    // R1: single select pins in isolation, op_hi as MSB.
    apply(4, 0, 0, "R1");       // NAND -> FF
    apply(1, 8'h12, 8'h34, "R1"); // ADD -> 46
    apply(2, 8'h81, 0, "R1");   // DBL -> 02
    // R8: wrap-around boundaries.
    apply(1, 8'hFF, 8'h01, "R8");
    apply(0, 8'h00, 8'h01, "R8");
    apply(2, 8'hFF, 8'h00, "R8");
    // R9: carry-in only on subtract; zero second operand elsewhere.
    apply(0, 8'h05, 8'h05, "R9");
    apply(3, 8'h01, 8'hFF, "R9");
    // R7: in_b ignored while inverting.
    apply(7, 8'h5A, 8'h00, "R7");
    apply(7, 8'h5A, 8'hFF, "R7");
    // Exhaustive sweep of every code and operand pair.
    for (int code = 0; code < 8; code++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          apply(code, a, b, tag_of(code));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule